// File: doc/BRIEF.md
# Multi-Mode Interrupt Vector Sequencer

This block decides when an 8-bit processor core takes an interrupt and what the core does next. The core tells it where instruction boundaries fall and passes on the executed enable, disable and mode-select instructions. The block keeps the interrupt-enable state and the current response mode. When a pending request meets an enabled boundary, it strobes an acknowledge to the peripheral and captures the byte the peripheral drives onto the data bus.

There are three response modes. In the opcode mode the captured byte goes back to the core as an instruction to execute; normally this is a restart opcode. In the fixed mode the core is asked to push its PC and call one constant address. In the table mode the captured byte and an 8-bit base value form the address of a table entry. The block issues two back-to-back memory reads for the two bytes of that entry. It then asks the core to push its PC and call the 16-bit target built from them, low byte first.

Top module: `irq_vector_seq`

## Requirements
- R1: After a synchronous reset, the response mode is the opcode mode (value 0) and interrupts are disabled. `int_ack`, `exec_valid`, `call_valid`, `rd_valid` and `busy` are all low.
- R2: A request on `irq_req` is accepted only in a cycle where `ins_boundary` is high and interrupts are enabled. A request at any other time has no effect on the outputs.
- R3: `cmd_en` is sampled only with `ins_boundary`. No request is accepted at the boundary that carries `cmd_en`. Interrupts become enabled from the next boundary onward, which is the one that ends the following instruction.
- R4: `cmd_dis` is sampled only with `ins_boundary`. It blocks acceptance at that boundary and at every later one until a new enable. If `cmd_dis` and `cmd_en` arrive together, `cmd_dis` wins.
- R5: On acceptance, `int_ack` is high for exactly one cycle, in the cycle after the accepting boundary, and interrupts are disabled again.
- R6: `cmd_mode` with `ins_boundary` loads `mode_sel` into the mode register for the values 0 (opcode), 1 (fixed) and 2 (table). The value 3 leaves the mode unchanged.
- R7: Opcode mode: the bus byte present during the `int_ack` cycle appears on `exec_op`, and `exec_valid` pulses for one cycle in the next cycle.
- R8: Fixed mode: `call_valid` pulses in the cycle after `int_ack`, with `call_addr` = 0x0038.
- R9: Table mode: in the two cycles after `int_ack`, `rd_valid` is high with `rd_addr` = {base, byte[7:1], 0} and then with that address plus one. `rd_data` is taken one cycle after each read. `call_valid` pulses two cycles after the second read, with `call_addr` = {second byte, first byte}.
- R10: `busy` is high from the `int_ack` cycle through the last table read cycle, and low in the cycle of the `exec_valid` or `call_valid` pulse. No request is accepted while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | Level interrupt request |
| ins_boundary | input | 1 | Core is between two instructions this cycle |
| cmd_en | input | 1 | Enable-interrupts instruction completed |
| cmd_dis | input | 1 | Disable-interrupts instruction completed |
| cmd_mode | input | 1 | Mode-select instruction completed |
| mode_sel | input | 2 | Mode value carried by the mode-select instruction |
| base_reg | input | 8 | Table base (high address byte) |
| bus_byte | input | 8 | Byte placed on the data bus by the peripheral |
| rd_data | input | 8 | Memory read data, one cycle after a read |
| int_ack | output | 1 | Interrupt acknowledge strobe |
| exec_valid | output | 1 | Request to execute `exec_op` |
| exec_op | output | 8 | Opcode captured from the bus |
| call_valid | output | 1 | Request to push PC and jump |
| call_addr | output | 16 | Jump target |
| rd_valid | output | 1 | Memory read request |
| rd_addr | output | 16 | Memory read address |
| busy | output | 1 | Sequence in progress |

## Verification
Two things can land on the same boundary: a pending request and an enable or disable command. The bench provokes both cases. It holds `irq_req` high while the boundary carries `cmd_en`, and expects no acknowledge there but an acknowledge exactly one cycle after the next boundary. It also raises `cmd_dis` at a boundary while interrupts are enabled and a request is pending, and expects no acknowledge at that boundary or at later ones. Random mode, bus byte and base value sequences are then checked for read addresses and call targets computed in the bench.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef logic [1:0] mode_t;
  localparam mode_t MODE_OPCODE = 2'd0;
  localparam mode_t MODE_FIXED  = 2'd1;
  localparam mode_t MODE_TABLE  = 2'd2;
  localparam mode_t MODE_NONE   = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACK,
    ST_RD0,
    ST_RD1,
    ST_RD2
  } seq_state_t;
endpackage

// File: rtl/irq_gate.sv
// Enable and mode bookkeeping driven by boundary-qualified commands.
module irq_gate
  import irq_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  ins_boundary,
  input  logic  cmd_en,
  input  logic  cmd_dis,
  input  logic  cmd_mode,
  input  mode_t mode_sel,
  input  logic  accept,
  output mode_t mode_q,
  output logic  int_on,
  output logic  can_take
);
  logic ie_q;
  logic arm_q;

  assign int_on   = ie_q | arm_q;
  // A boundary carrying an enable/disable command never accepts.
  assign can_take = int_on & ~cmd_en & ~cmd_dis;

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q   <= 1'b0;
      arm_q  <= 1'b0;
      mode_q <= MODE_OPCODE;
    end else begin
      if (accept) begin
        ie_q  <= 1'b0;
        arm_q <= 1'b0;
      end else if (ins_boundary) begin
        if (cmd_dis) begin
          ie_q  <= 1'b0;
          arm_q <= 1'b0;
        end else if (cmd_en) begin
          arm_q <= 1'b1;
        end else if (arm_q) begin
          ie_q  <= 1'b1;
          arm_q <= 1'b0;
        end
      end
      if (ins_boundary && cmd_mode && (mode_sel != MODE_NONE)) begin
        mode_q <= mode_sel;
      end
    end
  end
endmodule

// File: rtl/irq_seq_fsm.sv
// Acknowledge, bus capture, table fetch and core request sequencing.
module irq_seq_fsm
  import irq_seq_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 2 * DATA_W,
  parameter logic [ADDR_W-1:0] FIXED_VEC = 16'h0038
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ins_boundary,
  input  logic              irq_req,
  input  logic              can_take,
  input  mode_t             mode_q,
  input  logic [DATA_W-1:0] base_reg,
  input  logic [DATA_W-1:0] bus_byte,
  input  logic [DATA_W-1:0] rd_data,
  output logic              accept,
  output logic              int_ack,
  output logic              exec_valid,
  output logic [DATA_W-1:0] exec_op,
  output logic              call_valid,
  output logic [ADDR_W-1:0] call_addr,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              busy
);
  seq_state_t        state_q;
  logic [DATA_W-1:0] lo_q;

  assign accept = (state_q == ST_IDLE) & ins_boundary & irq_req & can_take;
  assign busy   = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      lo_q       <= '0;
      int_ack    <= 1'b0;
      exec_valid <= 1'b0;
      exec_op    <= '0;
      call_valid <= 1'b0;
      call_addr  <= '0;
      rd_valid   <= 1'b0;
      rd_addr    <= '0;
    end else begin
      int_ack    <= 1'b0;
      exec_valid <= 1'b0;
      call_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            int_ack <= 1'b1;
            state_q <= ST_ACK;
          end
        end
        ST_ACK: begin
          if (mode_q == MODE_FIXED) begin
            call_valid <= 1'b1;
            call_addr  <= FIXED_VEC;
            state_q    <= ST_IDLE;
          end else if (mode_q == MODE_TABLE) begin
            rd_valid <= 1'b1;
            rd_addr  <= {base_reg, bus_byte[DATA_W-1:1], 1'b0};
            state_q  <= ST_RD0;
          end else begin
            exec_valid <= 1'b1;
            exec_op    <= bus_byte;
            state_q    <= ST_IDLE;
          end
        end
        ST_RD0: begin
          rd_addr[0] <= 1'b1;
          state_q    <= ST_RD1;
        end
        ST_RD1: begin
          rd_valid <= 1'b0;
          lo_q     <= rd_data;
          state_q  <= ST_RD2;
        end
        ST_RD2: begin
          call_valid <= 1'b1;
          call_addr  <= {rd_data, lo_q};
          state_q    <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_vector_seq.sv
module irq_vector_seq
  import irq_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [2*DATA_W-1:0] FIXED_VEC = 16'h0038
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  irq_req,
  input  logic                  ins_boundary,
  input  logic                  cmd_en,
  input  logic                  cmd_dis,
  input  logic                  cmd_mode,
  input  logic [1:0]            mode_sel,
  input  logic [DATA_W-1:0]     base_reg,
  input  logic [DATA_W-1:0]     bus_byte,
  input  logic [DATA_W-1:0]     rd_data,
  output logic                  int_ack,
  output logic                  exec_valid,
  output logic [DATA_W-1:0]     exec_op,
  output logic                  call_valid,
  output logic [2*DATA_W-1:0]   call_addr,
  output logic                  rd_valid,
  output logic [2*DATA_W-1:0]   rd_addr,
  output logic                  busy
);
  localparam int ADDR_W = 2 * DATA_W;

  mode_t mode_q;
  logic  int_on;
  logic  can_take;
  logic  accept;

  irq_gate u_gate (
    .clk          (clk),
    .rst          (rst),
    .ins_boundary (ins_boundary),
    .cmd_en       (cmd_en),
    .cmd_dis      (cmd_dis),
    .cmd_mode     (cmd_mode),
    .mode_sel     (mode_sel),
    .accept       (accept),
    .mode_q       (mode_q),
    .int_on       (int_on),
    .can_take     (can_take)
  );

  irq_seq_fsm #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .FIXED_VEC (FIXED_VEC)
  ) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .ins_boundary (ins_boundary),
    .irq_req      (irq_req),
    .can_take     (can_take),
    .mode_q       (mode_q),
    .base_reg     (base_reg),
    .bus_byte     (bus_byte),
    .rd_data      (rd_data),
    .accept       (accept),
    .int_ack      (int_ack),
    .exec_valid   (exec_valid),
    .exec_op      (exec_op),
    .call_valid   (call_valid),
    .call_addr    (call_addr),
    .rd_valid     (rd_valid),
    .rd_addr      (rd_addr),
    .busy         (busy)
  );
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] FIXED_VEC = 16'h0038
) (
  input logic              clk,
  input logic              rst,
  input logic              irq_req,
  input logic              ins_boundary,
  input logic              int_ack,
  input logic              exec_valid,
  input logic              call_valid,
  input logic [ADDR_W-1:0] call_addr,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              busy,
  input logic              int_on
);
  p_ack_cause_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(int_ack) |-> $past(ins_boundary && irq_req));

  p_ack_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    int_ack |=> !int_ack);

  p_ack_disables_r5: assert property (@(posedge clk) disable iff (rst)
    int_ack |-> !int_on);

  p_fixed_target_r8: assert property (@(posedge clk) disable iff (rst)
    (call_valid && $past(int_ack)) |-> (call_addr == FIXED_VEC));

  p_read_pair_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_valid) |=> (rd_valid && (rd_addr == $past(rd_addr) + 1'b1)));

  p_one_event_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({int_ack, exec_valid, call_valid, rd_valid}));

  p_busy_block_r10: assert property (@(posedge clk) disable iff (rst)
    busy |=> !int_ack);
endmodule

bind irq_vector_seq irq_seq_chk #(
  .ADDR_W    (2 * DATA_W),
  .FIXED_VEC (FIXED_VEC)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .irq_req      (irq_req),
  .ins_boundary (ins_boundary),
  .int_ack      (int_ack),
  .exec_valid   (exec_valid),
  .call_valid   (call_valid),
  .call_addr    (call_addr),
  .rd_valid     (rd_valid),
  .rd_addr      (rd_addr),
  .busy         (busy),
  .int_on       (int_on)
);

// File: tb/tb_irq_vector_seq.sv
module tb_irq_vector_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        irq_req = 1'b0;
  logic        ins_boundary = 1'b0;
  logic        cmd_en = 1'b0;
  logic        cmd_dis = 1'b0;
  logic        cmd_mode = 1'b0;
  logic [1:0]  mode_sel = 2'd0;
  logic [7:0]  base_reg = 8'h00;
  logic [7:0]  bus_byte = 8'h00;
  logic [7:0]  rd_data;
  logic        int_ack, exec_valid, call_valid, rd_valid, busy;
  logic [7:0]  exec_op;
  logic [15:0] call_addr, rd_addr;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_vector_seq dut (
    .clk(clk), .rst(rst), .irq_req(irq_req), .ins_boundary(ins_boundary),
    .cmd_en(cmd_en), .cmd_dis(cmd_dis), .cmd_mode(cmd_mode), .mode_sel(mode_sel),
    .base_reg(base_reg), .bus_byte(bus_byte), .rd_data(rd_data),
    .int_ack(int_ack), .exec_valid(exec_valid), .exec_op(exec_op),
    .call_valid(call_valid), .call_addr(call_addr), .rd_valid(rd_valid),
    .rd_addr(rd_addr), .busy(busy)
  );

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  function automatic logic [15:0] tbl_addr(input logic [7:0] base, input logic [7:0] b);
    return {base, b[7:1], 1'b0};
  endfunction

  // memory model: one cycle read latency
  always @(posedge clk) rd_data <= rd_valid ? memf(rd_addr) : 8'h00;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic bnd(input bit en, input bit dis, input bit mw, input logic [1:0] mv);
    ins_boundary = 1'b1; cmd_en = en; cmd_dis = dis; cmd_mode = mw; mode_sel = mv;
    tick();
    ins_boundary = 1'b0; cmd_en = 1'b0; cmd_dis = 1'b0; cmd_mode = 1'b0; mode_sel = 2'd0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    irq_req = 1'b0;
    bnd(1'b0, 1'b0, 1'b1, m);
  endtask

  task automatic enable_now();
    irq_req = 1'b0;
    bnd(1'b1, 1'b0, 1'b0, 2'd0);
  endtask

  // Request at a boundary and follow the expected response for mode m.
  task automatic take(input logic [1:0] m, input logic [7:0] b, input logic [7:0] base);
    logic [15:0] a;
    logic [15:0] tgt;
    a = tbl_addr(base, b);
    tgt = {memf(a | 16'h1), memf(a)};
    bus_byte = b; base_reg = base; irq_req = 1'b1;
    bnd(1'b0, 1'b0, 1'b0, 2'd0);
    irq_req = 1'b0;
    chk(int_ack === 1'b1, "R5 ack after boundary", int_ack, 1);
    chk(busy === 1'b1, "R10 busy in ack cycle", busy, 1);
    tick();
    bus_byte = ~b;
    chk(int_ack === 1'b0, "R5 ack one cycle", int_ack, 0);
    if (m == 2'd0) begin
      chk(exec_valid && exec_op == b, "R7 opcode", {exec_valid, exec_op}, {1'b1, b});
      chk(!busy, "R10 busy low on pulse", busy, 0);
    end else if (m == 2'd1) begin
      chk(call_valid && call_addr == 16'h0038, "R8 fixed call", {call_valid, call_addr}, {1'b1, 16'h0038});
      chk(!busy, "R10 busy low on pulse", busy, 0);
    end else begin
      chk(rd_valid && rd_addr == a, "R9 first read", {rd_valid, rd_addr}, {1'b1, a});
      chk(busy, "R10 busy in reads", busy, 1);
      tick();
      chk(rd_valid && rd_addr == (a | 16'h1), "R9 second read", {rd_valid, rd_addr}, {1'b1, a | 16'h1});
      tick();
      chk(!rd_valid && !call_valid, "R9 gap cycle", {rd_valid, call_valid}, 0);
      tick();
      chk(call_valid && call_addr == tgt, "R9 table call", {call_valid, call_addr}, {1'b1, tgt});
      chk(!busy, "R10 busy low on pulse", busy, 0);
    end
    tick();
    chk(!exec_valid && !call_valid && !busy && !int_ack, "R5 sequence ends", {exec_valid, call_valid, busy}, 0);
  endtask

  task automatic no_take(input string req);
    irq_req = 1'b1;
    bnd(1'b0, 1'b0, 1'b0, 2'd0);
    chk(int_ack === 1'b0, req, int_ack, 0);
    irq_req = 1'b0;
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    tick(); tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    chk({int_ack, exec_valid, call_valid, rd_valid, busy} == 5'b0, "R1 idle outputs",
        {int_ack, exec_valid, call_valid, rd_valid, busy}, 0);
    no_take("R1 disabled after reset");

    // R2 request without boundary ignored while enabled
    enable_now();
    bnd(1'b0, 1'b0, 1'b0, 2'd0);
    irq_req = 1'b1;
    repeat (5) tick();
    chk(int_ack === 1'b0 && busy === 1'b0, "R2 no boundary no ack", int_ack, 0);
    irq_req = 1'b0;
    // R1 reset mode is opcode mode
    take(2'd0, 8'hFF, 8'h00);
    // R5 disabled again after acceptance
    no_take("R5 auto disable");

    // R3 request held at the enable boundary, accepted at the next one
    irq_req = 1'b1;
    bnd(1'b1, 1'b0, 1'b0, 2'd0);
    chk(int_ack === 1'b0, "R3 no ack at enable boundary", int_ack, 0);
    take(2'd0, 8'hC7, 8'h00);

    // R4 disable with pending request on an enabled boundary
    enable_now();
    bnd(1'b0, 1'b0, 1'b0, 2'd0);
    irq_req = 1'b1;
    bnd(1'b0, 1'b1, 1'b0, 2'd0);
    chk(int_ack === 1'b0, "R4 no ack at disable boundary", int_ack, 0);
    no_take("R4 stays disabled");
    // R4 enable and disable together: disable wins
    irq_req = 1'b0;
    bnd(1'b1, 1'b1, 1'b0, 2'd0);
    no_take("R4 disable wins");
    no_take("R4 disable wins later");

    // R8 fixed mode, then R6 value 3 ignored
    set_mode(2'd1);
    enable_now();
    take(2'd1, 8'h12, 8'h34);
    set_mode(2'd3);
    enable_now();
    take(2'd1, 8'hAB, 8'h00);

    // R9 table mode with odd byte (bit 0 dropped)
    set_mode(2'd2);
    enable_now();
    take(2'd2, 8'h0F, 8'hFE);
    enable_now();
    take(2'd2, 8'hFF, 8'hFF);

    // R6 random mode mix
    for (int i = 0; i < 40; i++) begin
      logic [1:0] m;
      m = 2'($urandom_range(0, 2));
      set_mode(m);
      repeat ($urandom_range(0, 2)) bnd(1'b0, 1'b0, 1'b0, 2'd0);
      enable_now();
      take(m, 8'($urandom), 8'($urandom));
      if (i % 8 == 0) no_take("R5 auto disable random");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule